// File: doc/BRIEF.md
# Running Disparity Monitor

This block watches a stream of 8-bit characters, one per cycle when a valid strobe is high. For each accepted character it works out the signed balance of set bits against clear bits and sorts that balance into positive, negative or neutral. It also adds the balance to a signed running total that starts at zero after reset or after a clear. On a DC-balanced link that total should wander close to zero. A total that drifts away from zero points to a corrupted stream, so the block raises a flag when the magnitude of the total goes beyond a configurable bound.

The per-character results are registered and come out one cycle after the character, marked by an output valid. The running total and the violation flag are registered in the same cycle. The flag stays set until a synchronous clear, which also returns the total to zero. Once the total is past the bound it is held within a saturation limit, so its width stays fixed however long the fault lasts.

Top module: `rdm_monitor`

## Requirements
- R1: The reported character disparity is the count of 1 bits minus the count of 0 bits of the accepted character, as a signed value: 0x78 gives 0, 0x7F gives +6, 0x00 gives -8 and 0xFF gives +8.
- R2: The class output is 2'b01 when the character disparity is above zero, 2'b10 when it is below zero and 2'b00 when it is zero.
- R3: `out_valid_o` is high in exactly the cycle after a cycle with `char_valid_i` high, and the disparity and class outputs are updated in that same cycle. While no character is accepted, those outputs keep their last values.
- R4: `run_disp_o` equals the signed sum of the disparities of all characters accepted since the last reset or clear, and it is updated in the same cycle as `out_valid_o`.
- R5: When `char_valid_i` and `clear_i` are both low, neither the running total nor the violation flag changes.
- R6: `bound_viol_o` rises in the same cycle as the running-total update that makes the magnitude of the total strictly greater than BOUND (default 8). A total of exactly +BOUND or -BOUND does not set it.
- R7: Once set, `bound_viol_o` stays high until `clear_i` is asserted, even when the total comes back inside the bound.
- R8: A high `clear_i` makes the running total 0 and the flag low in the next cycle. If a character arrives in the same cycle as the clear, its disparity is left out of the total, but its per-character outputs are still reported.
- R9: The running total is held within ±(BOUND+8). A sum outside that range takes the value of the nearer limit.
- R10: After reset, `out_valid_o` is low, the disparity, class and running total are 0 and the flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| char_valid_i | input | 1 | A character is presented this cycle |
| char_data_i | input | CHAR_W (8) | Character bits |
| clear_i | input | 1 | Synchronous clear of the running total and the flag |
| out_valid_o | output | 1 | Per-character results are fresh this cycle |
| char_disp_o | output | DISP_W (5) | Signed disparity of the last accepted character |
| char_class_o | output | 2 | Sign class: 01 positive, 10 negative, 00 neutral |
| run_disp_o | output | RUN_W (6) | Signed, saturated running total |
| bound_viol_o | output | 1 | Sticky flag for a total beyond the bound |

## Verification
A bad popcount or a bad class decode shows on the per-character outputs in the cycle right after the character. A corrupted accumulator shows on `run_disp_o` at the next accepted character and stays wrong until a clear. The directed sequences walk the total to exactly the bound, then one step past it, then back inside, so that an off-by-one in the comparison or a flag that is not sticky shows up within one or two characters. The sequences also drive the total into saturation in both directions, and they raise a clear in the same cycle as a character, so that the priority between the two paths shows on `run_disp_o`.

// File: rtl/rdm_pkg.sv
package rdm_pkg;

    // Sign class of one character's bit balance
    typedef enum logic [1:0] {
        DCLS_NEUTRAL = 2'b00,
        DCLS_POS     = 2'b01,
        DCLS_NEG     = 2'b10
    } disp_class_e;

endpackage

// File: rtl/rdm_char_disp.sv
// Combinational balance of one character: ones minus zeros, plus its sign class.
module rdm_char_disp
    import rdm_pkg::*;
#(
    parameter int CHAR_W = 8,
    parameter int DISP_W = $clog2(CHAR_W + 1) + 1
) (
    input  logic [CHAR_W-1:0]        data_i,
    output logic signed [DISP_W-1:0] disp_o,
    output disp_class_e              class_o
);

    localparam int CNT_W = DISP_W - 1;

    logic [CNT_W-1:0]        ones;
    logic signed [DISP_W-1:0] twice_ones;

    // Count set bits
    always_comb begin
        ones = '0;
        for (int i = 0; i < CHAR_W; i++) begin
            ones = ones + CNT_W'(data_i[i]);
        end
    end

    // ones - zeros == 2*ones - CHAR_W
    always_comb begin
        twice_ones = signed'({ones, 1'b0});
        disp_o     = twice_ones - DISP_W'(CHAR_W);
    end

    always_comb begin
        if (disp_o > 0) begin
            class_o = DCLS_POS;
        end else if (disp_o < 0) begin
            class_o = DCLS_NEG;
        end else begin
            class_o = DCLS_NEUTRAL;
        end
    end

endmodule

// File: rtl/rdm_accum.sv
// Saturating signed running total with sticky bound-violation flag.
module rdm_accum #(
    parameter int DISP_W = 5,
    parameter int BOUND  = 8,
    parameter int LIMIT  = 16,
    parameter int ACC_W  = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     upd_i,
    input  logic                     clr_i,
    input  logic signed [DISP_W-1:0] disp_i,
    output logic signed [ACC_W-1:0]  run_o,
    output logic                     viol_o
);

    localparam logic signed [ACC_W-1:0] LIM_P  = ACC_W'(LIMIT);
    localparam logic signed [ACC_W-1:0] NLIM_P = -LIM_P;
    localparam logic signed [ACC_W-1:0] BND_P  = ACC_W'(BOUND);
    localparam logic signed [ACC_W-1:0] NBND_P = -BND_P;

    typedef struct packed {
        logic signed [ACC_W-1:0] run;
        logic                    viol;
    } acc_state_t;

    acc_state_t st_d, st_q;
    logic signed [ACC_W-1:0] disp_ext_d;
    logic signed [ACC_W-1:0] sum_d;
    logic signed [ACC_W-1:0] sat_d;

    always_comb begin
        disp_ext_d = signed'({{(ACC_W - DISP_W){disp_i[DISP_W-1]}}, disp_i});
        sum_d      = st_q.run + disp_ext_d;
        if (sum_d > LIM_P) begin
            sat_d = LIM_P;
        end else if (sum_d < NLIM_P) begin
            sat_d = NLIM_P;
        end else begin
            sat_d = sum_d;
        end

        st_d = st_q;
        if (clr_i) begin
            st_d.run  = '0;
            st_d.viol = 1'b0;
        end else if (upd_i) begin
            st_d.run  = sat_d;
            st_d.viol = st_q.viol | (sat_d > BND_P) | (sat_d < NBND_P);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run_o  = st_q.run;
    assign viol_o = st_q.viol;

    assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (run_o == '0) && !viol_o);

    assert_sticky_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_o && !clr_i) |=> viol_o);

    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_i && !clr_i) |=> ($stable(run_o) && $stable(viol_o)));

    assert_sat_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o <= LIM_P) && (run_o >= NLIM_P));

    assert_out_of_bound_flagged_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((run_o > BND_P) || (run_o < NBND_P)) |-> viol_o);

endmodule

// File: rtl/rdm_monitor.sv
// Top: registers per-character balance and class, drives the running-total tracker.
module rdm_monitor
    import rdm_pkg::*;
#(
    parameter int CHAR_W = 8,
    parameter int BOUND  = 8,
    parameter int DISP_W = $clog2(CHAR_W + 1) + 1,
    parameter int RUN_W  = $clog2(BOUND + 2 * CHAR_W + 1) + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     char_valid_i,
    input  logic [CHAR_W-1:0]        char_data_i,
    input  logic                     clear_i,
    output logic                     out_valid_o,
    output logic signed [DISP_W-1:0] char_disp_o,
    output logic [1:0]               char_class_o,
    output logic signed [RUN_W-1:0]  run_disp_o,
    output logic                     bound_viol_o
);

    localparam int LIMIT = BOUND + CHAR_W;

    typedef struct packed {
        logic                     vld;
        logic signed [DISP_W-1:0] disp;
        disp_class_e              cls;
    } char_out_t;

    char_out_t                co_d, co_q;
    logic signed [DISP_W-1:0] calc_disp;
    disp_class_e              calc_cls;

    rdm_char_disp #(
        .CHAR_W (CHAR_W),
        .DISP_W (DISP_W)
    ) u_char_disp (
        .data_i  (char_data_i),
        .disp_o  (calc_disp),
        .class_o (calc_cls)
    );

    always_comb begin
        co_d     = co_q;
        co_d.vld = char_valid_i;
        if (char_valid_i) begin
            co_d.disp = calc_disp;
            co_d.cls  = calc_cls;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            co_q <= '{vld: 1'b0, disp: '0, cls: DCLS_NEUTRAL};
        end else begin
            co_q <= co_d;
        end
    end

    rdm_accum #(
        .DISP_W (DISP_W),
        .BOUND  (BOUND),
        .LIMIT  (LIMIT),
        .ACC_W  (RUN_W)
    ) u_accum (
        .clk    (clk),
        .rst_n  (rst_n),
        .upd_i  (char_valid_i),
        .clr_i  (clear_i),
        .disp_i (calc_disp),
        .run_o  (run_disp_o),
        .viol_o (bound_viol_o)
    );

    assign out_valid_o  = co_q.vld;
    assign char_disp_o  = co_q.disp;
    assign char_class_o = co_q.cls;

    assert_valid_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid_i |=> out_valid_o);

    assert_no_spurious_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !char_valid_i |=> !out_valid_o);

    assert_char_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !char_valid_i |=> ($stable(char_disp_o) && $stable(char_class_o)));

    assert_class_matches_sign_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> (((char_disp_o > 0) == (char_class_o == 2'b01)) &&
                         ((char_disp_o < 0) == (char_class_o == 2'b10))));

    assert_disp_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> ((char_disp_o <= DISP_W'(CHAR_W)) && (char_disp_o >= -DISP_W'(CHAR_W))
                         && !char_disp_o[0]));

endmodule

// File: tb/rdm_monitor_tb_top.sv
`timescale 1ns/1ps
module rdm_monitor_tb_top;

    localparam int TB_BOUND = 8;
    localparam int TB_LIMIT = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              char_valid_i = 1'b0;
    logic [7:0]        char_data_i = '0;
    logic              clear_i = 1'b0;
    logic              out_valid_o;
    logic signed [4:0] char_disp_o;
    logic [1:0]        char_class_o;
    logic signed [5:0] run_disp_o;
    logic              bound_viol_o;

    int n_checks = 0;
    int n_fail   = 0;

    // model state
    int exp_disp = 0;
    int exp_cls  = 0;
    int exp_run  = 0;
    bit exp_viol = 0;
    bit exp_vld  = 0;

    always #2.5 clk = ~clk;

    rdm_monitor dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .char_valid_i (char_valid_i),
        .char_data_i  (char_data_i),
        .clear_i      (clear_i),
        .out_valid_o  (out_valid_o),
        .char_disp_o  (char_disp_o),
        .char_class_o (char_class_o),
        .run_disp_o   (run_disp_o),
        .bound_viol_o (bound_viol_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int balance(input logic [7:0] c);
        int ones = 0;
        for (int i = 0; i < 8; i++) ones += c[i];
        return ones - (8 - ones);
    endfunction

    // One cycle: drive at negedge, let a posedge capture, sample at the next negedge.
    task automatic step(input bit v, input logic [7:0] d, input bit c);
        int b;
        char_valid_i = v;
        char_data_i  = d;
        clear_i      = c;
        b = balance(d);
        exp_vld = v;
        if (v) begin
            exp_disp = b;
            exp_cls  = (b > 0) ? 1 : ((b < 0) ? 2 : 0);
        end
        if (c) begin
            exp_run  = 0;
            exp_viol = 0;
        end else if (v) begin
            exp_run = exp_run + b;
            if (exp_run > TB_LIMIT) exp_run = TB_LIMIT;
            if (exp_run < -TB_LIMIT) exp_run = -TB_LIMIT;
            if (exp_run > TB_BOUND || exp_run < -TB_BOUND) exp_viol = 1;
        end
        @(posedge clk);
        @(negedge clk);
        char_valid_i = 1'b0;
        clear_i      = 1'b0;
    endtask

    task automatic check_all(input string tag);
        check({tag, " out_valid R3"}, int'(out_valid_o), int'(exp_vld));
        check({tag, " char_disp R1"}, int'(char_disp_o), exp_disp);
        check({tag, " class R2"}, int'(char_class_o), exp_cls);
        check({tag, " run_disp R4"}, int'(run_disp_o), exp_run);
        check({tag, " viol R6"}, int'(bound_viol_o), int'(exp_viol));
    endtask

    task automatic test_reset();
        check("reset out_valid R10", int'(out_valid_o), 0);
        check("reset char_disp R10", int'(char_disp_o), 0);
        check("reset class R10", int'(char_class_o), 0);
        check("reset run R10", int'(run_disp_o), 0);
        check("reset viol R10", int'(bound_viol_o), 0);
    endtask

    task automatic test_char_values();
        step(0, 8'h00, 1); check_all("clr");
        step(1, 8'h78, 0); check_all("0x78 R1");
        check("0x78 disp R1", int'(char_disp_o), 0);
        step(1, 8'h7F, 0); check_all("0x7F R1");
        check("0x7F disp R1", int'(char_disp_o), 6);
        step(1, 8'h00, 0); check_all("0x00 R1");
        check("0x00 class R2", int'(char_class_o), 2);
        step(1, 8'hFF, 0); check_all("0xFF R1");
        step(1, 8'h01, 0); check_all("0x01 R4");
        check("sum back to zero R4", int'(run_disp_o), 0);
    endtask

    task automatic test_idle();
        step(1, 8'h0F, 0); check_all("neutral R2");
        step(1, 8'h07, 0); check_all("neg before idle");
        for (int k = 0; k < 3; k++) begin
            step(0, 8'hFF, 0); check_all("idle R5");
            check("idle disp held R3", int'(char_disp_o), -2);
        end
    endtask

    task automatic test_bound();
        step(0, 8'h00, 1); check_all("clr R8");
        step(1, 8'hFF, 0); check_all("at +bound R6");
        check("exactly bound no flag R6", int'(bound_viol_o), 0);
        step(1, 8'h03, 0); check_all("back in R4");
        step(1, 8'h3F, 0); check_all("at bound again R6");
        step(1, 8'h7F, 0); check_all("past bound R6");
        check("flag set past bound R6", int'(bound_viol_o), 1);
        step(1, 8'h00, 0); check_all("back inside sticky R7");
        check("sticky R7", int'(bound_viol_o), 1);
        step(0, 8'h00, 0); check_all("idle sticky R7");
        step(0, 8'h00, 1); check_all("clear R8");
        check("clear flag R8", int'(bound_viol_o), 0);
    endtask

    task automatic test_saturate();
        for (int k = 0; k < 4; k++) begin
            step(1, 8'hFF, 0); check_all("sat pos R9");
        end
        check("pos limit R9", int'(run_disp_o), 16);
        step(1, 8'h00, 0); check_all("off pos limit R9");
        check("after sat R9", int'(run_disp_o), 8);
        step(0, 8'h00, 1); check_all("clr");
        for (int k = 0; k < 3; k++) begin
            step(1, 8'h00, 0); check_all("sat neg R9");
        end
        check("neg limit R9", int'(run_disp_o), -16);
        check("neg flag R6", int'(bound_viol_o), 1);
    endtask

    task automatic test_clear_with_char();
        step(1, 8'h7F, 1); check_all("clear+char R8");
        check("clear drops char R8", int'(run_disp_o), 0);
        check("clear still reports R8", int'(out_valid_o), 1);
        step(1, 8'h1F, 0); check_all("after clear R4");
        check("fresh total R4", int'(run_disp_o), 2);
    endtask

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_char_values();
        test_idle();
        test_bound();
        test_saturate();
        test_clear_with_char();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule